// File: doc/BRIEF.md
# Configuration Block Stream Parser

This block reads the byte stream that comes sequentially out of a serial configuration memory and turns it into double-word register writes. The stream is a run of configuration blocks. The type byte at the start of each block selects its format. A single-write block carries one address and one 32-bit data word. A counted-run block carries a start address, a 16-bit count and that many data words. The words of a counted run go to consecutive double-word addresses.

Bytes arrive on an 8-bit valid/ready input. Each finished double word is presented as an address/data pair on a valid/ready write port. The write is held until the port accepts it, and no further byte is consumed while it waits. A stream-end input tells the parser that the memory has run out. If this happens between blocks, parsing ends cleanly and the done flag rises. A malformed block, or a stream that ends inside a block, raises a sticky error flag. In both cases the parser halts until a synchronous reset.

Top module: `cfg_stream_parser`

## Requirements
- R1: After a synchronous reset, `done`, `error` and `wr_valid` are 0 and `in_ready` is 1. Reset also discards a partially received block, so the next block is decoded from its type byte.
- R2: The type byte carries the block type in bits 1:0 and reserved bits in bits 7:2. Type 0 selects a single-write block and type 1 selects a counted-run block.
- R3: A single-write block is 7 bytes: the type byte, the address low byte, the address high byte, then data bytes 7:0, 15:8, 23:16 and 31:24. It issues one write. The write has `wr_addr = {addr_hi, addr_lo, 2'b00}` and `wr_data` equal to the four data bytes, least significant byte first.
- R4: A counted-run block is: the type byte, two address bytes, two count bytes (low byte first), then count data fields of 4 bytes each. Data field n starts at byte offset 4n+5. It issues one write per field, in order.
- R5: In a counted run the write address starts at the header address and rises by 4 after each field. It wraps modulo 2^ADDR_W.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, `wr_addr` and `wr_data` stay stable, and `in_ready` is 0 whenever `wr_valid` is 1.
- R7: A type code of 2 or 3, any nonzero reserved bit, or a count of zero sets `error`. The error is sticky until reset. After it, `in_ready` and `wr_valid` stay 0.
- R8: If `stream_end` is high while the parser waits for a type byte, `done` is set on the next edge. Done is sticky until reset, and `in_ready` and `wr_valid` stay 0 afterwards. `stream_end` takes priority over a byte offered in the same cycle.
- R9: If `stream_end` is high while the parser waits for any other byte of a block, `error` is set and `done` stays 0.
- R10: Blocks of either type follow one another with no gap bytes. The next byte after a block's last write is accepted is that block's successor's type byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Parser takes the byte at this edge |
| stream_end | input | 1 | No more stream bytes |
| wr_valid | output | 1 | Write request pending |
| wr_addr | output | ADDR_W | Byte address of the double word, bits 1:0 zero |
| wr_data | output | 32 | Double word to write |
| wr_ready | input | 1 | Write target accepts the request |
| done | output | 1 | Stream ended cleanly at a block boundary |
| error | output | 1 | Malformed block or truncated stream |

## Verification
A write request rises on the cycle after the edge that takes the fourth data byte of a field. It stays up through every cycle in which `wr_ready` is low. The `done` and `error` flags rise one edge after the parser samples the stream-end input or the offending byte. The bench records each write at the falling edge before the accepting rising edge. It reads the flags at falling edges a whole cycle or more after the stimulus. The write port is stalled in a repeating pattern during the counted runs, which tests the hold and no-consume rules while words are pending.

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              stream_end,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_ready,
  output logic              done,
  output logic              error
);
  localparam int DW_W = ADDR_W - 2;

  typedef enum logic [2:0] {
    ST_TYPE, ST_ALO, ST_AHI, ST_CLO, ST_CHI, ST_DATA, ST_WR, ST_HALT
  } state_t;

  state_t           state;
  logic             seq;
  logic [7:0]       addr_lo, cnt_lo;
  logic [15:0]      left;
  logic [DW_W-1:0]  dw;
  logic [1:0]       bidx;
  logic [31:0]      data;

  logic byte_st, take;
  assign byte_st  = (state == ST_ALO) || (state == ST_AHI) || (state == ST_CLO) ||
                    (state == ST_CHI) || (state == ST_DATA);
  assign in_ready = (state == ST_TYPE || byte_st) && !stream_end;
  assign take     = in_ready && in_valid;
  assign wr_valid = (state == ST_WR);
  assign wr_addr  = {dw, 2'b00};
  assign wr_data  = data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_TYPE;
      done    <= 1'b0;
      error   <= 1'b0;
      seq     <= 1'b0;
      addr_lo <= '0;
      cnt_lo  <= '0;
      left    <= '0;
      dw      <= '0;
      bidx    <= '0;
      data    <= '0;
    end else if (stream_end && state == ST_TYPE) begin
      done  <= 1'b1;
      state <= ST_HALT;
    end else if (stream_end && byte_st) begin
      error <= 1'b1;
      state <= ST_HALT;
    end else begin
      case (state)
        ST_TYPE: if (take) begin
          if (in_data[7:2] != 6'd0 || in_data[1]) begin
            error <= 1'b1;
            state <= ST_HALT;
          end else begin
            seq   <= in_data[0];
            state <= ST_ALO;
          end
        end
        ST_ALO: if (take) begin
          addr_lo <= in_data;
          state   <= ST_AHI;
        end
        ST_AHI: if (take) begin
          dw    <= DW_W'({in_data, addr_lo});
          bidx  <= '0;
          state <= seq ? ST_CLO : ST_DATA;
        end
        ST_CLO: if (take) begin
          cnt_lo <= in_data;
          state  <= ST_CHI;
        end
        ST_CHI: if (take) begin
          if ({in_data, cnt_lo} == 16'd0) begin
            error <= 1'b1;
            state <= ST_HALT;
          end else begin
            left  <= {in_data, cnt_lo};
            state <= ST_DATA;
          end
        end
        ST_DATA: if (take) begin
          data <= {in_data, data[31:8]};
          bidx <= bidx + 2'd1;
          if (bidx == 2'd3) state <= ST_WR;
        end
        ST_WR: if (wr_ready) begin
          if (seq && left != 16'd1) begin
            left  <= left - 16'd1;
            dw    <= dw + 1'b1;
            state <= ST_DATA;
          end else begin
            state <= ST_TYPE;
          end
        end
        default: state <= ST_HALT;
      endcase
    end
  end
endmodule

module cfg_stream_parser_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        in_data,
  input logic              in_ready,
  input logic              stream_end,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              wr_ready,
  input logic              done,
  input logic              error
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R6
  AST_NO_TAKE_WHILE_WR: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !in_ready); // R6
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_addr[1:0] == 2'b00); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    error |=> error); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (done || error) |-> !in_ready && !wr_valid); // R7
  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && error)); // R9
  AST_END_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    stream_end |-> !in_ready); // R8
endmodule

bind cfg_stream_parser cfg_stream_parser_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_cfg_stream_parser.sv
module tb_cfg_stream_parser;
  localparam int AW = 18;

  logic clk = 0, rst = 1, in_valid = 0, stream_end = 0, wr_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, wr_valid, done, error;
  logic [AW-1:0] wr_addr;
  logic [31:0] wr_data;

  cfg_stream_parser #(.ADDR_W(AW)) dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int ncap = 0, hold_bad = 0, stalls = 0, cyc = 0;
  bit stall_en = 0;
  logic [AW-1:0] cap_addr [64];
  logic [31:0] cap_data [64];
  logic [AW-1:0] hold_a;
  logic [31:0] hold_d;
  bit holding = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (holding && !(wr_valid && wr_addr == hold_a && wr_data == hold_d)) hold_bad++;
    if (wr_valid && in_ready) hold_bad++;
    holding = 0;
    wr_ready = stall_en ? (cyc % 4 == 0) : 1'b1;
    if (wr_valid && wr_ready) begin
      if (ncap < 64) begin cap_addr[ncap] = wr_addr; cap_data[ncap] = wr_data; end
      ncap++;
    end else if (wr_valid) begin
      stalls++; holding = 1; hold_a = wr_addr; hold_d = wr_data;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; stream_end = 0;
    repeat (2) @(negedge clk);
    rst = 0; ncap = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk); in_valid = 1; in_data = b; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1 in_valid = 0;
  endtask

  task automatic try_byte(logic [7:0] b);
    @(negedge clk); in_valid = 1; in_data = b;
    repeat (3) @(negedge clk);
    in_valid = 0;
  endtask

  task automatic send_single(logic [15:0] a, logic [31:0] d);
    send_byte(8'h00); send_byte(a[7:0]); send_byte(a[15:8]);
    for (int i = 0; i < 4; i++) send_byte(d[8*i +: 8]);
  endtask

  task automatic send_seq(logic [15:0] a, logic [15:0] n, logic [31:0] base);
    send_byte(8'h01); send_byte(a[7:0]); send_byte(a[15:8]);
    send_byte(n[7:0]); send_byte(n[15:8]);
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 4; i++) send_byte(((base + k) >> (8*i)) & 8'hFF);
  endtask

  task automatic settle(); repeat (10) @(negedge clk); endtask

  localparam logic [47:0] VEC [4] = '{
    48'h0000_00000001, 48'hFFFF_A5A5C3C3, 48'h1234_89ABCDEF, 48'h8001_00FF7E01 };

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 done", done, 0); chk("R1 error", error, 0);
    chk("R1 wr_valid", wr_valid, 0); chk("R1 in_ready", in_ready, 1);

    // R3 R10 table of single-write blocks, back to back
    for (int v = 0; v < 4; v++) begin
      send_single(VEC[v][47:32], VEC[v][31:0]);
      settle();
      chk("R3 count", ncap, v + 1);
      chk("R3 addr", cap_addr[v], {VEC[v][47:32], 2'b00});
      chk("R3 data", cap_data[v], VEC[v][31:0]);
    end
    chk("R10 no error", error, 0);

    // R4 R5 R6 counted run with stalls, then a single block (R10)
    do_reset(); stall_en = 1;
    send_seq(16'h0100, 16'd3, 32'hCAFE0000);
    settle();
    chk("R4 count", ncap, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R5 addr", cap_addr[k], 18'h00400 + 4 * k);
      chk("R4 data", cap_data[k], 32'hCAFE0000 + k);
    end
    send_single(16'h0002, 32'h13579BDF);
    settle();
    chk("R10 after run", cap_addr[3], 18'h00008);
    chk("R6 hold", hold_bad, 0);
    chk("R6 stalled", stalls > 0, 1);
    stall_en = 0;

    // R5 wrap
    do_reset();
    send_seq(16'hFFFF, 16'd2, 32'h00000010);
    settle();
    chk("R5 wrap a0", cap_addr[0], 18'h3FFFC);
    chk("R5 wrap a1", cap_addr[1], 18'h00000);

    // R4 count low byte first, R8 done at boundary
    do_reset();
    send_seq(16'h0040, 16'h0005, 32'h0);
    settle();
    chk("R4 count order", ncap, 5);
    @(negedge clk); stream_end = 1; in_valid = 1; in_data = 8'h00;
    @(negedge clk); #1;
    chk("R8 done", done, 1); chk("R8 no error", error, 0);
    chk("R8 in_ready", in_ready, 0);
    stream_end = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    chk("R8 sticky", done, 1); chk("R8 no writes", ncap, 5);

    // R7 / R2 error cases
    do_reset(); send_byte(8'h02); @(negedge clk);
    chk("R7 type2", error, 1);
    try_byte(8'h00); chk("R7 halted", in_ready, 0);
    do_reset(); send_byte(8'h03); @(negedge clk); chk("R7 type3", error, 1);
    do_reset(); send_byte(8'h40); @(negedge clk); chk("R2 reserved", error, 1);
    do_reset(); send_byte(8'h01); send_byte(8'h10); send_byte(8'h00);
    send_byte(8'h00); send_byte(8'h00); @(negedge clk);
    chk("R7 count0", error, 1);
    try_byte(8'h55); try_byte(8'h55); try_byte(8'h55); try_byte(8'h55);
    chk("R7 no writes", ncap, 0); chk("R7 wr_valid", wr_valid, 0);

    // R9 end mid-block
    do_reset(); send_byte(8'h00); send_byte(8'h21);
    @(negedge clk); stream_end = 1; @(negedge clk); #1;
    chk("R9 error", error, 1); chk("R9 done", done, 0);
    stream_end = 0;

    // R1 reset drops a partial block
    do_reset(); send_byte(8'h00); send_byte(8'h77);
    do_reset(); send_single(16'h0003, 32'h0BADF00D); settle();
    chk("R1 partial addr", cap_addr[0], 18'h0000C);
    chk("R1 partial data", cap_data[0], 32'h0BADF00D);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule